// File: doc/BRIEF.md
# Bus-Programmable Watchdog Timer

This block is a watchdog timer that sits on a simple single-cycle register bus. Software stores a 16-bit timeout, measured in ticks, in a count register. It then arms the timer through a control register and must keep restarting the countdown before it runs out. A parameterised clock divider produces the ticks. The default divider gives one tick per second from a 100 MHz clock, and the tick period can be changed through the parameter.

If the countdown runs out while the timer is armed, the block latches an expiry flag. It then drives a one-clock request on one of two outputs: a system reset request or a power-off request, selected by a control bit. After expiry the counter stays stopped until software reloads it. A hardware strap input can hold the watchdog inoperative. While the strap is high, the arm bit cannot be set and the strap level is visible in the control register.

The bus has two registers, selected by address bit 2: the control register at offset 0 and the count register at offset 4. Address bits 1:0 and any bits above bit 2 are ignored. The bus port is plain control signalling. Every access completes in one cycle and cannot be stalled, so there is no back-pressure.

Top module: `wdt_timer`

## Requirements
- R1: After reset both registers read 0, and `rst_req` and `pwroff_req` are low.
- R2: A write at offset 4 stores write-data bits 15:0 as the timeout. Bits 31:16 are ignored, and a read of offset 4 returns the timeout with bits 31:16 at 0.
- R3: A read of offset 0 returns the following: bit 0 is the arm bit, bit 1 is the expiry flag, bit 2 is the action select, bit 3 is the live strap level, and bits 31:4 are 0. Bit 7 (the reload request) always reads 0.
- R4: A write at offset 0 with bit 7 set loads the counter from the timeout and restarts the tick divider. With timeout N, the arm bit set and the strap low, the expiry request appears in the cycle that follows the (N+1)·TICK_DIV-th rising edge after the write edge.
- R5: Each reload before expiry cancels the pending expiry and restarts the full window from the latest reload.
- R6: On expiry the expiry flag is set and a single-cycle pulse is driven: on `rst_req` when control bit 2 is 0, and on `pwroff_req` when it is 1. The two outputs are never high together.
- R7: After expiry the counter stays stopped, and no further request is issued until the next reload.
- R8: A timeout of 0 expires on the first tick after reload, TICK_DIV cycles after the write edge.
- R9: Writing 1 to control bit 1 clears the expiry flag. Writing 0 to it leaves the flag unchanged.
- R10: While the arm bit (control bit 0) is 0, the countdown does not advance and no request is issued.
- R11: While `hold_off` is high, the arm bit reads 0 and cannot be set, bit 3 reads 1, and no request is issued.
- R12: Read data is registered. `bus_rdata` shows the addressed register in the cycle after a cycle with `bus_re` high, and it holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_off | input | 1 | Hardware strap; high keeps the watchdog inoperative |
| bus_addr | input | ADDR_W | Byte address; bit 2 selects control (0) or count (1) |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W | Registered read data |
| rst_req | output | 1 | One-cycle reset request on expiry |
| pwroff_req | output | 1 | One-cycle power-off request on expiry |

## Verification
The bench builds the block with TICK_DIV = 4 and the default 16-bit count. This makes a tick last four clocks, so every expiry window lands within a few dozen cycles and the exact expiry cycle can be predicted. Short timeouts (0 to 3) bring the zero-timeout case, repeated reloads, disarming mid-window and strap blocking within reach of one short run. The full-width timeout is exercised only through register read-back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Control register field positions (a driver decodes these)
  localparam int unsigned CTRL_RUN  = 0;
  localparam int unsigned CTRL_EXP  = 1;
  localparam int unsigned CTRL_ACT  = 2;
  localparam int unsigned CTRL_LOCK = 3;
  localparam int unsigned CTRL_KICK = 7;
  // Address bit that selects the count register
  localparam int unsigned SEL_BIT   = 2;

  typedef enum logic {
    ACT_RESET    = 1'b0,
    ACT_POWEROFF = 1'b1
  } wdt_action_e;

  typedef struct packed {
    logic        lock;
    wdt_action_e act;
    logic        expired;
    logic        run;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_off,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              expire_evt,
  output logic [DATA_W-1:0] bus_rdata,
  output wdt_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  timeout,
  output logic              kick
);
  logic hit_cnt;
  logic wr_ctrl;
  logic wr_cnt;
  logic run_q;
  logic exp_q;
  wdt_action_e act_q;
  logic [CNT_W-1:0]  timeout_q;
  logic [DATA_W-1:0] rd_next;
  logic unused_bits;

  assign hit_cnt = bus_addr[SEL_BIT];
  assign wr_ctrl = bus_we && !hit_cnt;
  assign wr_cnt  = bus_we && hit_cnt;
  assign kick    = wr_ctrl && bus_wdata[CTRL_KICK];
  assign unused_bits = ^{bus_addr, bus_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      exp_q     <= 1'b0;
      act_q     <= ACT_RESET;
      timeout_q <= '0;
    end else begin
      if (hold_off)
        run_q <= 1'b0;
      else if (wr_ctrl)
        run_q <= bus_wdata[CTRL_RUN];

      if (wr_ctrl)
        act_q <= wdt_action_e'(bus_wdata[CTRL_ACT]);

      if (expire_evt)
        exp_q <= 1'b1;
      else if (wr_ctrl && bus_wdata[CTRL_EXP])
        exp_q <= 1'b0;

      if (wr_cnt)
        timeout_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    ctrl.run     = run_q;
    ctrl.expired = exp_q;
    ctrl.act     = act_q;
    ctrl.lock    = hold_off;
  end

  assign timeout = timeout_q;

  always_comb begin
    rd_next = '0;
    if (hit_cnt)
      rd_next[CNT_W-1:0] = timeout_q;
    else
      rd_next[3:0] = ctrl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_re)
      bus_rdata <= rd_next;
  end
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int unsigned TICK_DIV = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic restart,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_bypass
      logic unused_in;
      assign unused_in = clk ^ rst_n;
      assign tick = enable && !restart;
    end else begin : g_div
      localparam int unsigned PRE_W = $clog2(TICK_DIV);
      localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] pre_q;
      logic at_last;

      assign at_last = (pre_q == LAST);
      assign tick    = enable && at_last && !restart;

      always_ff @(posedge clk) begin
        if (!rst_n || restart || !enable)
          pre_q <= '0;
        else if (at_last)
          pre_q <= '0;
        else
          pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run_eff,
  input  wdt_action_e      act,
  output logic             active,
  output logic             expire_evt,
  output logic             rst_req,
  output logic             pwroff_req
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step       = tick && run_eff && active && !kick;
  assign expire_evt = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      active <= 1'b0;
    end else if (kick) begin
      cnt_q  <= load_val;
      active <= 1'b1;
    end else if (step) begin
      if (cnt_q == '0)
        active <= 1'b0;
      else
        cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req    <= 1'b0;
      pwroff_req <= 1'b0;
    end else begin
      rst_req    <= expire_evt && (act == ACT_RESET);
      pwroff_req <= expire_evt && (act == ACT_POWEROFF);
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TICK_DIV = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_off,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic              pwroff_req
);
  wdt_ctrl_t        ctrl;
  logic [CNT_W-1:0] timeout;
  logic             kick;
  logic             expire_evt;
  logic             active;
  logic             run_eff;
  logic             tick;
  logic             run_bit;
  logic             expired_bit;

  assign run_eff     = ctrl.run && !hold_off;
  assign run_bit     = ctrl.run;
  assign expired_bit = ctrl.expired;

  wdt_regs #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_off  (hold_off),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .expire_evt(expire_evt),
    .bus_rdata (bus_rdata),
    .ctrl      (ctrl),
    .timeout   (timeout),
    .kick      (kick)
  );

  wdt_tick_gen #(
    .TICK_DIV(TICK_DIV)
  ) i_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (run_eff && active),
    .restart(kick),
    .tick   (tick)
  );

  wdt_downcount #(
    .CNT_W(CNT_W)
  ) i_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .kick      (kick),
    .load_val  (timeout),
    .run_eff   (run_eff),
    .act       (ctrl.act),
    .active    (active),
    .expire_evt(expire_evt),
    .rst_req   (rst_req),
    .pwroff_req(pwroff_req)
  );
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_off,
  input logic run_bit,
  input logic expired_bit,
  input logic rst_req,
  input logic pwroff_req
);
  // R6
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && pwroff_req));
  // R6
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R6
  pwroff_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwroff_req |=> !pwroff_req);
  // R6
  flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || pwroff_req) |-> expired_bit);
  // R11
  strap_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_off) |-> !(rst_req || pwroff_req));
  // R10
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_bit) |-> !(rst_req || pwroff_req));
endmodule

bind wdt_timer wdt_timer_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hold_off   (hold_off),
  .run_bit    (run_bit),
  .expired_bit(expired_bit),
  .rst_req    (rst_req),
  .pwroff_req (pwroff_req)
);

// File: tb/test_wdt_timer.sv
`timescale 1ns/1ps
module test_wdt_timer;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold_off = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  logic        pwroff_req;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  int exp_cyc[$];
  bit exp_kind[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_timer #(.TICK_DIV(DIV)) i_wdt_timer (
    .clk(clk), .rst_n(rst_n), .hold_off(hold_off),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .pwroff_req(pwroff_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, want);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic drop_pending();
    while (exp_cyc.size() > 0 && exp_cyc[$] > cyc) begin
      void'(exp_cyc.pop_back());
      void'(exp_kind.pop_back());
    end
  endtask

  // Write; a reload with arm predicts the expiry cycle for the scoreboard
  task automatic wr(input logic [2:0] a, input logic [31:0] d, input int tmo);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1;
    if (a[2] == 1'b0) begin
      drop_pending();
      if (d[7] && d[0] && !hold_off) begin
        exp_cyc.push_back(cyc + (tmo + 1) * DIV);
        exp_kind.push_back(d[2]);
      end
    end
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares each request pulse with the scoreboard front
  always @(negedge clk) begin
    if (rst_n && (rst_req || pwroff_req)) begin
      if (exp_cyc.size() == 0) begin
        chk("R7 R10 R11 unexpected request", {30'd0, pwroff_req, rst_req}, 32'd0);
      end else begin
        int c;
        bit k;
        c = exp_cyc.pop_front();
        k = exp_kind.pop_front();
        chk("R4 R5 R8 expiry cycle", cyc, c);
        chk("R6 request select", {30'd0, pwroff_req, rst_req}, k ? 32'd2 : 32'd1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1
    chk("R1 outputs", {30'd0, pwroff_req, rst_req}, 32'd0);
    rd(3'd0, v); chk("R1 control", v, 32'h0);
    rd(3'd4, v); chk("R1 count", v, 32'h0);
    // R2
    wr(3'd4, 32'hABCD_0005, 0);
    rd(3'd4, v); chk("R2 count upper ignored", v, 32'h5);
    // R4 timeout 5 reset action; R3 reload reads 0
    wr(3'd0, 32'h81, 5);
    rd(3'd0, v); chk("R3 control layout", v, 32'h1);
    idle(30);
    rd(3'd0, v); chk("R6 expired flag", v, 32'h3);
    idle(40); // R7 no further pulse
    // R9
    wr(3'd0, 32'h01, 0);
    rd(3'd0, v); chk("R9 write 0 keeps flag", v, 32'h3);
    wr(3'd0, 32'h02, 0);
    rd(3'd0, v); chk("R9 write 1 clears flag", v, 32'h0);
    // R6 power-off action
    wr(3'd4, 32'h2, 0);
    wr(3'd0, 32'h85, 2);
    idle(20);
    rd(3'd0, v); chk("R6 power-off flag", v, 32'h7);
    wr(3'd0, 32'h02, 0);
    // R5 repeated reloads
    wr(3'd4, 32'h3, 0);
    for (int i = 0; i < 5; i++) begin
      wr(3'd0, 32'h81, 3);
      idle(8);
    end
    idle(25);
    rd(3'd0, v); chk("R5 expired after last reload", v, 32'h3);
    wr(3'd0, 32'h02, 0);
    // R8 zero timeout
    wr(3'd4, 32'h0, 0);
    wr(3'd0, 32'h81, 0);
    idle(10);
    wr(3'd0, 32'h02, 0);
    // R10 disarm mid-window
    wr(3'd4, 32'h1, 0);
    wr(3'd0, 32'h81, 1);
    idle(2);
    wr(3'd0, 32'h00, 0);
    idle(30);
    rd(3'd0, v); chk("R10 disarmed no expiry", v, 32'h0);
    // R11 strap
    hold_off = 1'b1;
    wr(3'd0, 32'h81, 1);
    rd(3'd0, v); chk("R11 strap visible, arm blocked", v, 32'h8);
    idle(40);
    hold_off = 1'b0;
    idle(2);
    rd(3'd0, v); chk("R11 after strap release", v, 32'h0);
    // R12 read data holds
    rd(3'd4, v); chk("R12 read count", v, 32'h1);
    wr(3'd4, 32'h7, 0);
    idle(3);
    chk("R12 rdata held without read", bus_rdata, 32'h1);
    rd(3'd4, v); chk("R12 new read", v, 32'h7);
    idle(5);
    chk("R4 scoreboard drained", exp_cyc.size(), 32'd0);
    report();
  end
endmodule